// File: doc/BRIEF.md
# Supervisory Reset Generator with Address-Window Watchdog

This block is the reset supervisor of a processor board. It collects four reset causes: power-on (an asynchronous clear from the supply ramp), a falling supply reported by a comparator as a digital level, a manual push-button, and expiry of a watchdog timer. Every cause feeds one shared pulse stretcher. The stretcher drives a complementary pair of push-pull reset outputs, one active low and one active high. The pulse lasts a fixed number of ticks of a 1 kHz timebase-enable input, so the default of 140 ticks gives 140 ms.

The watchdog has no kick register. Any bus access whose address falls inside an eight-byte window retriggers it, whether the access is a read or a write. The watchdog runs only while its enable strap is high, and the strap is normally left low. While the board is held in reset, the watchdog count is cleared. After each expiry, the watchdog starts a fresh interval once the pulse has ended.

The push-button input passes through a two-flop synchronizer and a stable-level debounce filter, so contact bounce and short glitches are ignored. There is no data stream through this block. All of its pins are plain control levels and strobes with no handshake.

Top module: `sup_reset_gen`

## Requirements
- R1: `rst_out_n` is always the inverse of `rst_out`. Both outputs are asserted (`rst_out_n`=0, `rst_out`=1) while `por_n` is low.
- R2: After `por_n` rises, the reset pulse ends after exactly PULSE_TICKS ticks, provided no other cause is active.
- R3: A low `pwr_ok` starts or holds a reset. After `pwr_ok` returns high and has passed its two-flop synchronizer, the pulse ends after PULSE_TICKS more ticks.
- R4: A low level on `mr_n` is accepted, and starts a reset, only after it has stayed stable for DEBOUNCE_TICKS ticks. Shorter lows and bounces have no effect on the outputs.
- R5: After `mr_n` is released, the pulse ends after DEBOUNCE_TICKS + PULSE_TICKS ticks.
- R6: A cause that asserts during an active pulse reloads the full PULSE_TICKS count.
- R7: With `wd_strap` low, the watchdog never produces a reset.
- R8: With `wd_strap` high and no retrigger, a reset starts after WD_TICKS ticks spent out of reset. Each expiry is followed by a new interval of WD_TICKS ticks, counted from the end of the pulse.
- R9: A cycle with `bus_strobe` high and `bus_addr` in WIN_BASE to WIN_BASE+7 (the address bits above bit 2 match) restarts the watchdog interval. Addresses outside that window do not restart it.
- R10: The watchdog count is held at zero while reset is active, so it cannot expire during a pulse.
- R11: A pulse ends only on a tick cycle in which no reset cause is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Asynchronous power-on clear, active low |
| tick | input | 1 | One-cycle timebase enable, 1 kHz |
| pwr_ok | input | 1 | Supply-above-threshold level from the comparator (asynchronous) |
| mr_n | input | 1 | Manual reset button, active low, raw and undebounced |
| wd_strap | input | 1 | Watchdog enable strap, high runs the watchdog |
| bus_strobe | input | 1 | High for one cycle per bus read or write |
| bus_addr | input | ADDR_W | Address of the current bus access |
| rst_out_n | output | 1 | Reset output, active low |
| rst_out | output | 1 | Reset output, active high |

## Verification
The assertions check several rules on every cycle. The outputs must stay complementary. A live cause must hold reset on the following cycle. A pulse may end only on a quiet tick. The watchdog may fire only for a single cycle, never while reset is active, never right after a window hit and never with the strap low. Exact pulse lengths, debounce acceptance and the length of each watchdog interval can only be shown by the bench scenarios. The bench aligns stimulus to the tick phase and counts ticks against PULSE_TICKS, DEBOUNCE_TICKS and WD_TICKS. It also checks that in-window and out-of-window accesses affect the watchdog as required.

// File: rtl/sup_pkg.sv
package sup_pkg;
  // Bits needed to hold the values 0..n
  function automatic int cnt_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  // Level-sensitive reset causes feeding the stretcher
  typedef struct packed {
    logic droop;
    logic manual;
    logic wdog;
  } rst_src_t;
endpackage

// File: rtl/sup_sync2.sv
module sup_sync2 #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);
  logic meta;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/sup_debounce.sv
module sup_debounce #(
  parameter int unsigned STABLE_TICKS = 10
) (
  input  logic clk,
  input  logic arst_n,
  input  logic tick,
  input  logic din,
  output logic dout
);
  localparam int CW = sup_pkg::cnt_bits(STABLE_TICKS);
  localparam logic [CW-1:0] LAST = CW'(STABLE_TICKS - 1);

  logic [CW-1:0] cnt;

  // dout follows din only after din has differed from it for STABLE_TICKS ticks
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt  <= '0;
      dout <= 1'b1;
    end else if (din == dout) begin
      cnt <= '0;
    end else if (tick) begin
      if (cnt == LAST) begin
        dout <= din;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sup_wdog.sv
module sup_wdog #(
  parameter int unsigned WD_TICKS = 1600,
  parameter int unsigned ADDR_W   = 24,
  parameter int unsigned WIN_LG2  = 3,
  parameter logic [ADDR_W-1:0] WIN_BASE = 'h814000
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              tick,
  input  logic              enable,
  input  logic              hold,
  input  logic              strobe,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic              fire
);
  localparam int CW = sup_pkg::cnt_bits(WD_TICKS);
  localparam logic [CW-1:0] LAST = CW'(WD_TICKS - 1);

  logic [CW-1:0]     cnt;
  logic [ADDR_W-1:0] diff;

  // Any access whose upper address bits match the window base is a retrigger
  assign diff = (addr ^ WIN_BASE) >> WIN_LG2;
  assign hit  = strobe && (diff == '0);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt  <= '0;
      fire <= 1'b0;
    end else begin
      fire <= 1'b0;
      if (!enable || hold || hit) begin
        cnt <= '0;
      end else if (tick) begin
        if (cnt == LAST) begin
          fire <= 1'b1;
          cnt  <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sup_stretch.sv
module sup_stretch #(
  parameter int unsigned PULSE_TICKS = 140
) (
  input  logic clk,
  input  logic arst_n,
  input  logic tick,
  input  logic trigger,
  output logic active
);
  localparam int CW = sup_pkg::cnt_bits(PULSE_TICKS);
  localparam logic [CW-1:0] FULL = CW'(PULSE_TICKS);

  logic [CW-1:0] remain;

  // A live cause reloads the full count; a quiet tick consumes one step
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)                      remain <= FULL;
    else if (trigger)                 remain <= FULL;
    else if (tick && remain != '0)    remain <= remain - 1'b1;
  end

  assign active = (remain != '0);
endmodule

// File: rtl/sup_reset_gen.sv
module sup_reset_gen #(
  parameter int unsigned PULSE_TICKS    = 140,
  parameter int unsigned DEBOUNCE_TICKS = 10,
  parameter int unsigned WD_TICKS       = 1600,
  parameter int unsigned ADDR_W         = 24,
  parameter int unsigned WIN_LG2        = 3,
  parameter logic [ADDR_W-1:0] WIN_BASE = 'h814000
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              tick,
  input  logic              pwr_ok,
  input  logic              mr_n,
  input  logic              wd_strap,
  input  logic              bus_strobe,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              rst_out_n,
  output logic              rst_out
);
  import sup_pkg::*;

  logic     pwr_s, mr_s, mr_f;
  logic     wd_hit, wd_fire;
  logic     rst_active, src_any;
  rst_src_t src;

  sup_sync2 #(.RST_VAL(1'b1)) u_pwr_sync (
    .clk(clk), .arst_n(por_n), .d(pwr_ok), .q(pwr_s)
  );

  sup_sync2 #(.RST_VAL(1'b1)) u_mr_sync (
    .clk(clk), .arst_n(por_n), .d(mr_n), .q(mr_s)
  );

  sup_debounce #(.STABLE_TICKS(DEBOUNCE_TICKS)) u_mr_filt (
    .clk(clk), .arst_n(por_n), .tick(tick), .din(mr_s), .dout(mr_f)
  );

  sup_wdog #(
    .WD_TICKS(WD_TICKS), .ADDR_W(ADDR_W), .WIN_LG2(WIN_LG2), .WIN_BASE(WIN_BASE)
  ) u_wdog (
    .clk(clk), .arst_n(por_n), .tick(tick), .enable(wd_strap),
    .hold(rst_active), .strobe(bus_strobe), .addr(bus_addr),
    .hit(wd_hit), .fire(wd_fire)
  );

  assign src.droop  = ~pwr_s;
  assign src.manual = ~mr_f;
  assign src.wdog   = wd_fire;
  assign src_any    = |src;

  sup_stretch #(.PULSE_TICKS(PULSE_TICKS)) u_stretch (
    .clk(clk), .arst_n(por_n), .tick(tick), .trigger(src_any), .active(rst_active)
  );

  assign rst_out   = rst_active;
  assign rst_out_n = ~rst_active;
endmodule

// File: rtl/sup_reset_gen_chk.sv
module sup_reset_gen_chk (
  input logic clk,
  input logic por_n,
  input logic tick,
  input logic wd_strap,
  input logic rst_out_n,
  input logic rst_out,
  input logic src_any,
  input logic rst_active,
  input logic wd_hit,
  input logic wd_fire
);
  // R1: output pair stays complementary
  a_r1_complement: assert property (@(posedge clk) disable iff (!por_n)
    rst_out_n != rst_out);

  // R6: a live cause keeps reset asserted on the next cycle
  a_r6_source_holds: assert property (@(posedge clk) disable iff (!por_n)
    src_any |=> rst_active);

  // R11: reset releases only after a quiet tick
  a_r11_release_on_tick: assert property (@(posedge clk) disable iff (!por_n)
    $fell(rst_active) |-> ($past(tick) && !$past(src_any)));

  // R7: strap low, watchdog silent
  a_r7_strap_off: assert property (@(posedge clk) disable iff (!por_n)
    (!wd_strap && !$past(wd_strap)) |-> !wd_fire);

  // R10: no expiry while reset is active
  a_r10_no_fire_in_reset: assert property (@(posedge clk) disable iff (!por_n)
    rst_active |=> !wd_fire);

  // R9: a window hit restarts the interval, so no expiry follows it
  a_r9_hit_retriggers: assert property (@(posedge clk) disable iff (!por_n)
    wd_hit |=> !wd_fire);

  // R8: expiry is a single-cycle event
  a_r8_fire_single: assert property (@(posedge clk) disable iff (!por_n)
    wd_fire |=> !wd_fire);
endmodule

bind sup_reset_gen sup_reset_gen_chk u_chk (
  .clk(clk), .por_n(por_n), .tick(tick), .wd_strap(wd_strap),
  .rst_out_n(rst_out_n), .rst_out(rst_out), .src_any(src_any),
  .rst_active(rst_active), .wd_hit(wd_hit), .wd_fire(wd_fire)
);

// File: tb/sup_reset_gen_tb.sv
`timescale 1ns/1ps
module sup_reset_gen_tb;
  localparam int P   = 5;
  localparam int DEB = 3;
  localparam int WD  = 12;
  localparam int AW  = 24;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          por_n = 1'b0, tick = 1'b0, pwr_ok = 1'b1, mr_n = 1'b1;
  logic          wd_strap = 1'b0, bus_strobe = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic          rst_out_n, rst_out;

  sup_reset_gen #(
    .PULSE_TICKS(P), .DEBOUNCE_TICKS(DEB), .WD_TICKS(WD), .ADDR_W(AW),
    .WIN_LG2(3), .WIN_BASE(24'h814000)
  ) u_dut (
    .clk(clk), .por_n(por_n), .tick(tick), .pwr_ok(pwr_ok), .mr_n(mr_n),
    .wd_strap(wd_strap), .bus_strobe(bus_strobe), .bus_addr(bus_addr),
    .rst_out_n(rst_out_n), .rst_out(rst_out)
  );

  int  checks = 0, errors = 0;
  bit  done = 0;
  int  cyc = 0;
  bit  tick_en = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Timebase: one tick every fourth cycle
  always @(posedge clk) begin
    #1;
    tick = tick_en && (cyc % 4 == 0);
    cyc++;
  end

  // Scoreboard: expected pulse lengths (ticks after all causes went quiet)
  int    exp_len[$];
  string exp_req[$];
  int    idle_age = 100, pulse_ticks = 0, gap_ticks = 0, last_gap = 0, pulses = 0;
  bit    act_d = 1;

  always @(negedge clk) begin
    if (por_n) begin
      bit act;
      act = !rst_out_n;
      if (pwr_ok && mr_n) idle_age++; else idle_age = 0;
      if (rst_out_n == rst_out) chk(0, "R1 complement", rst_out, !rst_out_n);
      if (act) begin
        if (tick && idle_age >= 3) pulse_ticks++;
      end else if (tick && wd_strap) begin
        gap_ticks++;
      end
      if (act && !act_d) last_gap = gap_ticks;
      if (!act && act_d) begin
        pulses++;
        if (exp_len.size() == 0) chk(0, "R4 R7 R9 unexpected pulse", pulse_ticks, 0);
        else begin
          int e;
          string r;
          e = exp_len.pop_front();
          r = exp_req.pop_front();
          chk(pulse_ticks == e, r, pulse_ticks, e);
        end
        pulse_ticks = 0;
        gap_ticks   = 0;
      end
      act_d = act;
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // Land in the cycle right after a tick cycle
  task automatic align();
    do @(negedge clk); while (!tick);
    @(posedge clk);
    #1;
  endtask

  task automatic wait_release();
    while (!rst_out_n) @(negedge clk);
    @(posedge clk);
    #1;
  endtask

  task automatic wait_pulse_done();
    while (rst_out_n) @(negedge clk);
    wait_release();
  endtask

  task automatic access(input logic [AW-1:0] a);
    bus_addr   = a;
    bus_strobe = 1'b1;
    @(posedge clk);
    #1;
    bus_strobe = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog timeout", 0, 1);
    finish_run();
  end

  initial begin
    int base;
    cycles(3);
    chk(rst_out_n == 0 && rst_out == 1, "R1 reset state", rst_out, 1);

    // R2 power-on pulse
    exp_len.push_back(P); exp_req.push_back("R2 power-on length");
    por_n = 1'b1; tick_en = 1;
    wait_release();
    chk(pulses == 1, "R2 pulse count", pulses, 1);

    // R7 strap low: nothing happens over three intervals
    align(); cycles(4 * 3 * WD);
    chk(pulses == 1 && rst_out_n == 1, "R7 strap off", pulses, 1);

    // R3 supply droop
    exp_len.push_back(P); exp_req.push_back("R3 droop length");
    align(); pwr_ok = 1'b0; cycles(12);
    align(); pwr_ok = 1'b1;
    wait_release();
    chk(pulses == 2, "R3 pulse count", pulses, 2);

    // R6 / R11 restart during countdown
    exp_len.push_back(P + 2); exp_req.push_back("R6 R11 restart length");
    align(); pwr_ok = 1'b0; cycles(12);
    align(); pwr_ok = 1'b1; cycles(8);
    pwr_ok = 1'b0; cycles(8);
    align(); pwr_ok = 1'b1;
    wait_release();

    // R4 glitch and bounce rejected
    align(); mr_n = 1'b0; cycles(4 * (DEB - 1)); mr_n = 1'b1; cycles(16);
    repeat (3) begin mr_n = 1'b0; cycles(4); mr_n = 1'b1; cycles(4); end
    cycles(4 * (P + DEB + 2));
    chk(pulses == 3 && rst_out_n == 1, "R4 glitch ignored", pulses, 3);

    // R4 accepted press, R5 release length
    exp_len.push_back(DEB + P); exp_req.push_back("R5 manual release length");
    align(); mr_n = 1'b0; cycles(4 * (DEB + 1));
    chk(rst_out_n == 0, "R4 press accepted", rst_out_n, 0);
    cycles(12); mr_n = 1'b1;
    wait_release();

    // R8 watchdog expiry and repeat interval; R10 count cleared during pulse
    exp_len.push_back(P); exp_req.push_back("R8 expiry length");
    exp_len.push_back(P); exp_req.push_back("R8 second expiry length");
    align(); gap_ticks = 0; wd_strap = 1'b1;
    wait_pulse_done();
    chk(last_gap == WD, "R8 first interval", last_gap, WD);
    wait_pulse_done();
    chk(last_gap == WD, "R8 R10 new interval after pulse", last_gap, WD);

    // R9 in-window accesses keep it quiet
    base = pulses;
    for (int i = 0; i < 6; i++) begin
      align();
      access((i % 2 == 0) ? 24'h814000 : 24'h814007);
      cycles(4 * (WD / 2));
    end
    chk(pulses == base && rst_out_n == 1, "R9 retrigger holds off", pulses, base);

    // R9 out-of-window accesses do not retrigger
    exp_len.push_back(P); exp_req.push_back("R9 expiry length");
    align(); gap_ticks = 0; access(24'h814003);
    for (int i = 0; i < 3; i++) begin
      align();
      access((i % 2 == 0) ? 24'h814008 : 24'h813FFF);
      cycles(8);
    end
    wait_pulse_done();
    wd_strap = 1'b0;
    chk(last_gap == WD, "R9 outside window ignored", last_gap, WD);
    chk(exp_len.size() == 0, "R8 all pulses seen", exp_len.size(), 0);

    cycles(20);
    finish_run();
  end
endmodule